// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Decoder

This block listens to the two open-collector lines of a PS/2 keyboard and turns the incoming byte stream into key events. The raw clock and data lines are brought into the system clock domain through a two-flop synchronizer. Each line then passes a glitch filter that accepts a new level only after it has held for `FILT_LEN` system clocks. A falling edge of the filtered keyboard clock shifts in one bit. After eleven bits the frame is checked. It must start with a 0 and end with a 1, and the eight data bits sent least significant first, together with the parity bit, must hold an odd number of ones.

The two prefix bytes are absorbed rather than reported. A 0xF0 byte arms a release marker and a 0xE0 byte arms an extended marker. The next ordinary byte is then reported as one event with both markers attached, and the markers are cleared. A held key resends its code periodically, and each repeat is simply another press event. A malformed frame raises a one-cycle error pulse, drops the byte and clears any armed prefix. If the keyboard clock stops in the middle of a frame for `TIMEOUT_CYC` system clocks, a watchdog returns the bit counter to idle so that the next frame is aligned again.

Top module: `ps2_key_decoder`

## Requirements
- R1: A frame of 11 bits, sampled on falling edges of the filtered keyboard clock, with bit 0 = start (0), bits 1..8 = data LSB first, bit 9 = parity, bit 10 = stop (1), produces `key_valid_o` high for one cycle with `key_code_o` equal to the data byte.
- R2: A frame whose data plus parity bit holds an even number of ones pulses `frame_err_o` for one cycle and produces no event.
- R3: A frame with a start bit of 1 or a stop bit of 0 pulses `frame_err_o` and produces no event.
- R4: A data byte 0xF0 produces no event; the next ordinary code is reported with `key_release_o` = 1.
- R5: A data byte 0xE0 produces no event; the next ordinary code is reported with `key_ext_o` = 1, and the sequence E0, F0, code reports both flags set.
- R6: A frame error clears any armed E0 or F0 prefix, so the next good code is reported with both flags 0.
- R7: Repeated identical codes each produce their own press event with both flags 0.
- R8: A low pulse on the keyboard clock shorter than `FILT_LEN` system clocks is not taken as a falling edge.
- R9: If no falling edge arrives for `TIMEOUT_CYC` system clocks while a frame is partly received, the bit counter returns to idle and the next complete frame is decoded correctly.
- R10: While and right after synchronous reset `rst` is high, `key_valid_o`, `frame_err_o`, `key_code_o`, `key_release_o` and `key_ext_o` are all 0.
- R11: `key_code_o`, `key_release_o` and `key_ext_o` change only in a cycle where `key_valid_o` is high and hold their value otherwise; `key_valid_o` and `frame_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Raw keyboard clock line, idles high |
| ps2_dat_i | input | 1 | Raw keyboard data line, idles high |
| key_valid_o | output | 1 | One-cycle strobe for a decoded key event |
| key_code_o | output | 8 | Scan code of the latest event |
| key_release_o | output | 1 | Latest event was a key release |
| key_ext_o | output | 1 | Latest event was an extended key |
| frame_err_o | output | 1 | One-cycle pulse on a malformed frame |

## Verification
The assertions assume that two frames are never closer together than a few system clocks. With that spacing the event and error strobes are isolated pulses, and a pulse that lasted two cycles would be a design fault. The stimulus meets this easily. It uses a keyboard clock with a 40-cycle bit period and leaves idle gaps between frames. It also sets data in the middle of the clock-high phase, so the filtered data line is settled well before each falling edge.

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder #(
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_release_o,
  output logic       key_ext_o,
  output logic       frame_err_o
);
  localparam int FW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [FW-1:0] FLAST = FW'(FILT_LEN - 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYC - 1);

  logic [1:0]    sync1, sync2, flt;
  logic [FW-1:0] fcnt [2];
  logic [3:0]    bitcnt;
  logic [9:0]    shreg;
  logic [TW-1:0] wcnt;
  logic          pend_rel, pend_ext;

  wire        fall     = flt[0] & ~sync2[0] & (fcnt[0] == FLAST);
  wire        done     = fall & (bitcnt == 4'd10);
  wire [10:0] frame    = {flt[1], shreg};
  wire [7:0]  byte_in  = frame[8:1];
  wire        frame_ok = ~frame[0] & frame[10] & (^frame[9:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 2'b11;
      sync2 <= 2'b11;
      flt   <= 2'b11;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      sync1 <= {ps2_dat_i, ps2_clk_i};
      sync2 <= sync1;
      for (int i = 0; i < 2; i++) begin
        if (sync2[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FLAST) begin
          flt[i]  <= sync2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt <= '0;
      shreg  <= '0;
      wcnt   <= '0;
    end else if (fall) begin
      wcnt   <= '0;
      shreg  <= {flt[1], shreg[9:1]};
      bitcnt <= (bitcnt == 4'd10) ? 4'd0 : bitcnt + 4'd1;
    end else if (bitcnt == 4'd0) begin
      wcnt <= '0;
    end else if (wcnt == TLAST) begin
      wcnt   <= '0;
      bitcnt <= '0;
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_valid_o   <= 1'b0;
      frame_err_o   <= 1'b0;
      key_code_o    <= '0;
      key_release_o <= 1'b0;
      key_ext_o     <= 1'b0;
      pend_rel      <= 1'b0;
      pend_ext      <= 1'b0;
    end else begin
      key_valid_o <= 1'b0;
      frame_err_o <= 1'b0;
      if (done) begin
        if (!frame_ok) begin
          frame_err_o <= 1'b1;
          pend_rel    <= 1'b0;
          pend_ext    <= 1'b0;
        end else if (byte_in == 8'hE0) begin
          pend_ext <= 1'b1;
        end else if (byte_in == 8'hF0) begin
          pend_rel <= 1'b1;
        end else begin
          key_valid_o   <= 1'b1;
          key_code_o    <= byte_in;
          key_release_o <= pend_rel;
          key_ext_o     <= pend_ext;
          pend_rel      <= 1'b0;
          pend_ext      <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_key_decoder_checker.sv
module ps2_key_decoder_checker (
  input logic       clk,
  input logic       rst,
  input logic       key_valid_o,
  input logic [7:0] key_code_o,
  input logic       key_release_o,
  input logic       key_ext_o,
  input logic       frame_err_o
);
  p_no_prefix_event_r4: assert property (@(posedge clk) disable iff (rst)
    key_valid_o |-> (key_code_o != 8'hF0));
  p_no_prefix_event_r5: assert property (@(posedge clk) disable iff (rst)
    key_valid_o |-> (key_code_o != 8'hE0));
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    key_valid_o |=> !key_valid_o);
  p_err_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);
  p_err_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(key_valid_o && frame_err_o));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !key_valid_o |-> ($stable(key_code_o) && $stable(key_release_o) && $stable(key_ext_o)));
endmodule

bind ps2_key_decoder ps2_key_decoder_checker u_chk (
  .clk(clk), .rst(rst), .key_valid_o(key_valid_o), .key_code_o(key_code_o),
  .key_release_o(key_release_o), .key_ext_o(key_ext_o), .frame_err_o(frame_err_o)
);

// File: tb/ps2_key_decoder_bench.sv
module ps2_key_decoder_bench;
  localparam int H = 20;
  logic clk = 0, rst = 1, ps2_clk = 1, ps2_dat = 1;
  logic       key_valid_o, key_release_o, key_ext_o, frame_err_o;
  logic [7:0] key_code_o;
  int total = 0, bad = 0, ev_cnt = 0, err_cnt = 0;
  logic [7:0] ev_code = 0;
  logic ev_rel = 0, ev_ext = 0, finished = 0;

  always #2 clk = ~clk;

  ps2_key_decoder #(.FILT_LEN(4), .TIMEOUT_CYC(200)) u_ps2_key_decoder (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .key_valid_o(key_valid_o), .key_code_o(key_code_o), .key_release_o(key_release_o),
    .key_ext_o(key_ext_o), .frame_err_o(frame_err_o));

  always @(negedge clk) if (!rst) begin
    if (key_valid_o) begin
      ev_cnt++; ev_code = key_code_o; ev_rel = key_release_o; ev_ext = key_ext_o;
    end
    if (frame_err_o) err_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk(input logic [7:0] d, input bit bp, input bit bs, input bit bt);
    return {~bt, (~^d) ^ bp, d, bs};
  endfunction

  task automatic send(input logic [10:0] b, input int nbits = 11);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk) ps2_dat = b[i];
      repeat (H/2) @(negedge clk);
      ps2_clk = 0;
      repeat (H) @(negedge clk);
      ps2_clk = 1;
      repeat (H/2) @(negedge clk);
    end
    ps2_dat = 1;
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_event(input string req, input int n0, input logic [7:0] c, input bit r, input bit e);
    check(ev_cnt == n0 + 1, req, ev_cnt - n0, 1);
    check(ev_code == c && ev_rel == r && ev_ext == e, req, {ev_code, 3'b0, ev_rel, 3'b0, ev_ext}, {c, 3'b0, r, 3'b0, e});
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check({key_valid_o, frame_err_o, key_code_o, key_release_o, key_ext_o} == 0, "R10", key_code_o, 0);
    rst = 0;
    @(negedge clk);
    check({key_valid_o, frame_err_o, key_code_o, key_release_o, key_ext_o} == 0, "R10", key_code_o, 0);
  endtask

  task automatic t_plain();
    int n;
    logic [7:0] codes [3] = '{8'h1C, 8'h5A, 8'h81};
    foreach (codes[k]) begin
      n = ev_cnt; send(mk(codes[k], 0, 0, 0)); expect_event("R1", n, codes[k], 0, 0);
    end
    repeat (40) @(negedge clk);
    check(key_code_o == 8'h81 && !key_valid_o, "R11", key_code_o, 8'h81);
  endtask

  task automatic t_repeat();
    int n = ev_cnt;
    for (int k = 0; k < 3; k++) send(mk(8'h2B, 0, 0, 0));
    check(ev_cnt == n + 3, "R7", ev_cnt - n, 3);
    check(ev_code == 8'h2B && !ev_rel && !ev_ext, "R7", ev_code, 8'h2B);
  endtask

  task automatic t_release();
    int n = ev_cnt;
    send(mk(8'hF0, 0, 0, 0));
    check(ev_cnt == n, "R4", ev_cnt - n, 0);
    send(mk(8'h1C, 0, 0, 0));
    expect_event("R4", n, 8'h1C, 1, 0);
  endtask

  task automatic t_ext();
    int n = ev_cnt;
    send(mk(8'hE0, 0, 0, 0));
    check(ev_cnt == n, "R5", ev_cnt - n, 0);
    send(mk(8'h75, 0, 0, 0));
    expect_event("R5", n, 8'h75, 0, 1);
    n = ev_cnt;
    send(mk(8'hE0, 0, 0, 0)); send(mk(8'hF0, 0, 0, 0)); send(mk(8'h75, 0, 0, 0));
    expect_event("R5", n, 8'h75, 1, 1);
  endtask

  task automatic t_errors();
    int n = ev_cnt, e = err_cnt;
    send(mk(8'h33, 1, 0, 0));
    check(err_cnt == e + 1 && ev_cnt == n, "R2", err_cnt - e, 1);
    send(mk(8'h33, 0, 1, 0));
    check(err_cnt == e + 2 && ev_cnt == n, "R3", err_cnt - e, 2);
    send(mk(8'h33, 0, 0, 1));
    check(err_cnt == e + 3 && ev_cnt == n, "R3", err_cnt - e, 3);
    send(mk(8'hE0, 0, 0, 0)); send(mk(8'hF0, 0, 0, 0));
    send(mk(8'h44, 1, 0, 0));
    send(mk(8'h44, 0, 0, 0));
    expect_event("R6", n, 8'h44, 0, 0);
  endtask

  task automatic t_glitch();
    int n = ev_cnt, e = err_cnt;
    @(negedge clk) ps2_clk = 0;
    repeat (2) @(negedge clk);
    ps2_clk = 1;
    repeat (30) @(negedge clk);
    send(mk(8'h4D, 0, 0, 0));
    expect_event("R8", n, 8'h4D, 0, 0);
    check(err_cnt == e, "R8", err_cnt - e, 0);
  endtask

  task automatic t_watchdog();
    int n = ev_cnt, e = err_cnt;
    send(mk(8'h66, 0, 0, 0), 5);
    repeat (400) @(negedge clk);
    send(mk(8'h29, 0, 0, 0));
    expect_event("R9", n, 8'h29, 0, 0);
    check(err_cnt == e, "R9", err_cnt - e, 0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_repeat();
    t_release();
    t_ext();
    t_errors();
    t_glitch();
    t_watchdog();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule